// File: doc/BRIEF.md
# Dual Audio Bit-Clock Divider

This block derives two audio-rate clocks from a small set of reference clocks. Channel A is meant to serve the 44.1 kHz sample-rate family and channel B the 48 kHz family. Each channel chooses one reference input through a 4-bit source field. It divides the ticks of that reference by a programmable amount and presents the result as a 50% duty output that changes level only on reference ticks.

Every reference is modelled as a one-cycle-wide tick in the single system clock domain. A divide word has two parts. The upper two bits pick a prescaler of 2, 8, 32 or 128, with the ratios four times apart. The lower eight bits give a count N, and the channel divides by prescaler × (N + 1). Software programs the block through a write-only bus of address, data and write strobe. A new divide word is held as pending and replaces the active one only at the end of the current full output period. A source code that names no populated reference forces that channel's output low and clears its enable status.

Top module: `audio_rate_clkgen`

## Requirements
- R1: After reset both outputs are low, both source fields are 0 so both enables are high, and both divide words are 2, which gives division by 6.
- R2: A divide word is bits 9:8 (prescaler code p) and bits 7:0 (N) of a write. The channel divides by (2 << 2p) × (N + 1) reference ticks. Bits 31:10 of the write are ignored. Address 1 holds the divide word of channel A and address 2 that of channel B.
- R3: The output holds each level for exactly half the division, (1 << 2p) × (N + 1) ticks of the selected reference, so the duty is 50%. Low is the first half after reset.
- R4: A divide word of 0 gives the minimum division of 2, and the output toggles on every selected tick.
- R5: A write to address 0 loads channel A's source field from bits 23:20 and channel B's from bits 19:16. All other bits of that write are ignored.
- R6: A source code k below NUM_REFS selects ref_tick[k]. The two channels count independently, even when both select the same reference.
- R7: A source code of NUM_REFS or above drives that channel's enable low at once. From the next clock its output is held low with the count cleared, until a valid code is written.
- R8: A divide word that is written during a period takes effect at the output falling edge that ends the current full period, never in the middle of it.
- R9: While its source is valid, a channel's output changes level only on a clock in which the selected reference ticks.
- R10: Writes to addresses other than 0, 1 and 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | NUM_REFS | One-cycle ticks of each reference clock |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| clk_a_out | output | 1 | Divided clock of channel A |
| clk_b_out | output | 1 | Divided clock of channel B |
| en_a | output | 1 | Channel A's source field names a populated reference |
| en_b | output | 1 | Channel B's source field names a populated reference |

## Verification
The hardest case to reach from the ports is a divide write or a source change that lands exactly on, or just before, a terminal count while the selected reference ticks irregularly. That is the point where the pending and active words could be confused. The stimulus drives one reference with a pseudo-random tick pattern and issues writes at many different phase offsets within a period. A behavioural model in the bench tracks the pending word, the active word and the tick count, and is compared with the outputs on every clock. An unpopulated source is also selected while the output is high, to show it is forced low and then resumes from a clean low half.

// File: rtl/arcg_pkg.sv
package arcg_pkg;
   localparam int NUM_CH      = 2;
   localparam int CH_A        = 0;
   localparam int CH_B        = 1;
   localparam int SEL_A_LSB   = 20;
   localparam int SEL_B_LSB   = 16;
   localparam int BUS_W       = 32;
   localparam int ADDR_SEL    = 0;
   localparam int ADDR_DIV_A  = 1;
   localparam int ADDR_DIV_B  = 2;
endpackage

// File: rtl/arcg_regs.sv
module arcg_regs
   import arcg_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int SEL_W       = 4,
   parameter int DIV_W       = 10,
   parameter logic [DIV_W-1:0] DIV_DEFAULT = DIV_W'(2)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_wr,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [BUS_W-1:0]                  bus_wdata,
   output logic [NUM_CH-1:0][SEL_W-1:0]      sel_q,
   output logic [NUM_CH-1:0][DIV_W-1:0]      div_q
);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(ADDR_SEL);
   localparam logic [ADDR_W-1:0] A_DIVA = ADDR_W'(ADDR_DIV_A);
   localparam logic [ADDR_W-1:0] A_DIVB = ADDR_W'(ADDR_DIV_B);

   logic wr_sel, wr_diva, wr_divb;

   always_comb begin
      wr_sel  = bus_wr && (bus_addr == A_SEL);
      wr_diva = bus_wr && (bus_addr == A_DIVA);
      wr_divb = bus_wr && (bus_addr == A_DIVB);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (wr_sel) begin
         sel_q[CH_A] <= bus_wdata[SEL_A_LSB +: SEL_W];
         sel_q[CH_B] <= bus_wdata[SEL_B_LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q[CH_A] <= DIV_DEFAULT;
         div_q[CH_B] <= DIV_DEFAULT;
      end else begin
         if (wr_diva) div_q[CH_A] <= bus_wdata[DIV_W-1:0];
         if (wr_divb) div_q[CH_B] <= bus_wdata[DIV_W-1:0];
      end
   end
endmodule

// File: rtl/arcg_refmux.sv
module arcg_refmux #(
   parameter int NUM_REFS = 4,
   parameter int SEL_W    = 4
) (
   input  logic [NUM_REFS-1:0] ref_tick,
   input  logic [SEL_W-1:0]    sel,
   output logic                populated,
   output logic                tick
);
   localparam int SPAN = 1 << SEL_W;

   logic [SPAN-1:0] pop_map;
   logic [SPAN-1:0] tick_map;

   generate
      for (genvar k = 0; k < SPAN; k++) begin : g_slot
         if (k < NUM_REFS) begin : g_real
            assign pop_map[k]  = 1'b1;
            assign tick_map[k] = ref_tick[k];
         end else begin : g_empty
            assign pop_map[k]  = 1'b0;
            assign tick_map[k] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      populated = pop_map[sel];
      tick      = tick_map[sel] & populated;
   end
endmodule

// File: rtl/arcg_divider.sv
module arcg_divider #(
   parameter int PRE_W = 2,
   parameter int CNT_W = 8,
   parameter int DIV_W = PRE_W + CNT_W,
   parameter logic [DIV_W-1:0] DIV_DEFAULT = DIV_W'(2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             populated,
   input  logic             tick,
   input  logic [DIV_W-1:0] div_pend,
   output logic [DIV_W-1:0] div_act,
   output logic             clk_out
);
   localparam int MAX_SHIFT = 2 * ((1 << PRE_W) - 1);
   localparam int HALF_W    = CNT_W + 1 + MAX_SHIFT;
   localparam int SH_W      = PRE_W + 1;

   logic [HALF_W-1:0] half_len;
   logic [HALF_W-1:0] cnt_q;
   logic [SH_W-1:0]   shamt;
   logic              terminal;

   always_comb begin
      shamt    = {div_act[DIV_W-1 -: PRE_W], 1'b0};
      half_len = HALF_W'({1'b0, div_act[CNT_W-1:0]} + (CNT_W+1)'(1)) << shamt;
      terminal = (cnt_q == half_len - HALF_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clk_out <= 1'b0;
         div_act <= DIV_DEFAULT;
      end else if (!populated) begin
         cnt_q   <= '0;
         clk_out <= 1'b0;
      end else if (tick) begin
         if (terminal) begin
            cnt_q   <= '0;
            clk_out <= ~clk_out;
            if (clk_out) div_act <= div_pend;
         end else begin
            cnt_q <= cnt_q + HALF_W'(1);
         end
      end
   end
endmodule

// File: rtl/audio_rate_clkgen.sv
module audio_rate_clkgen
   import arcg_pkg::*;
#(
   parameter int NUM_REFS = 4,
   parameter int ADDR_W   = 4,
   parameter int SEL_W    = 4,
   parameter int PRE_W    = 2,
   parameter int CNT_W    = 8,
   parameter int DIV_DEFAULT_VAL = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REFS-1:0] ref_tick,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic                clk_a_out,
   output logic                clk_b_out,
   output logic                en_a,
   output logic                en_b
);
   localparam int DIV_W = PRE_W + CNT_W;
   localparam logic [DIV_W-1:0] DIV_DEFAULT = DIV_W'(DIV_DEFAULT_VAL);

   generate
      if (NUM_REFS < 1 || NUM_REFS > (1 << SEL_W)) begin : g_bad_refs
         $error("NUM_REFS must lie in 1 .. 2**SEL_W");
      end
      if (SEL_W > 4) begin : g_bad_sel
         $error("SEL_W wider than the 4-bit source field");
      end
      if (DIV_W > 16 || PRE_W < 1) begin : g_bad_div
         $error("divide word layout out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too narrow for three registers");
      end
   endgenerate

   logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
   logic [NUM_CH-1:0][DIV_W-1:0] div_pend;
   logic [NUM_CH-1:0][DIV_W-1:0] div_act;
   logic [NUM_CH-1:0]            ch_pop;
   logic [NUM_CH-1:0]            ch_tick;
   logic [NUM_CH-1:0]            ch_out;

   arcg_regs #(
      .ADDR_W      (ADDR_W),
      .SEL_W       (SEL_W),
      .DIV_W       (DIV_W),
      .DIV_DEFAULT (DIV_DEFAULT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .sel_q     (sel_q),
      .div_q     (div_pend)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         arcg_refmux #(
            .NUM_REFS (NUM_REFS),
            .SEL_W    (SEL_W)
         ) u_mux (
            .ref_tick  (ref_tick),
            .sel       (sel_q[c]),
            .populated (ch_pop[c]),
            .tick      (ch_tick[c])
         );

         arcg_divider #(
            .PRE_W       (PRE_W),
            .CNT_W       (CNT_W),
            .DIV_W       (DIV_W),
            .DIV_DEFAULT (DIV_DEFAULT)
         ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .populated (ch_pop[c]),
            .tick      (ch_tick[c]),
            .div_pend  (div_pend[c]),
            .div_act   (div_act[c]),
            .clk_out   (ch_out[c])
         );
      end
   endgenerate

   assign clk_a_out = ch_out[CH_A];
   assign clk_b_out = ch_out[CH_B];
   assign en_a      = ch_pop[CH_A];
   assign en_b      = ch_pop[CH_B];
endmodule

// File: rtl/arcg_checker.sv
module arcg_checker #(
   parameter int NUM_REFS = 4,
   parameter int ADDR_W   = 4,
   parameter int SEL_W    = 4,
   parameter int DIV_W    = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_REFS-1:0] ref_tick,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic                out_a,
   input logic                out_b,
   input logic                en_a,
   input logic                en_b,
   input logic [SEL_W-1:0]    sel_a,
   input logic [DIV_W-1:0]    pend_a,
   input logic [DIV_W-1:0]    pend_b,
   input logic [DIV_W-1:0]    act_a,
   input logic [DIV_W-1:0]    act_b
);
   logic any_tick;
   assign any_tick = |ref_tick;

   AST_SEL_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(0)) |=> (sel_a == $past(bus_wdata[20 +: SEL_W]))); // R5
   AST_DIV_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(1)) |=> (pend_a == $past(bus_wdata[DIV_W-1:0]))); // R2
   AST_DIV_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(1)) |=> $stable(pend_a)); // R10
   AST_DIV_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(2)) |=> $stable(pend_b)); // R10
   AST_UNPOP_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_a |=> !out_a); // R7
   AST_UNPOP_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_b |=> !out_b); // R7
   AST_TICK_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_tick && en_a) |=> $stable(out_a)); // R9
   AST_TICK_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_tick && en_b) |=> $stable(out_b)); // R9
   AST_LOAD_AT_END_A: assert property (@(posedge clk) disable iff (!rst_n)
      (act_a != $past(act_a)) |-> $fell(out_a)); // R8
   AST_LOAD_AT_END_B: assert property (@(posedge clk) disable iff (!rst_n)
      (act_b != $past(act_b)) |-> $fell(out_b)); // R8
endmodule

bind audio_rate_clkgen arcg_checker #(
   .NUM_REFS (NUM_REFS),
   .ADDR_W   (ADDR_W),
   .SEL_W    (SEL_W),
   .DIV_W    (PRE_W + CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_tick  (ref_tick),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .out_a     (clk_a_out),
   .out_b     (clk_b_out),
   .en_a      (en_a),
   .en_b      (en_b),
   .sel_a     (sel_q[0]),
   .pend_a    (div_pend[0]),
   .pend_b    (div_pend[1]),
   .act_a     (div_act[0]),
   .act_b     (div_act[1])
);

// File: tb/test_audio_rate_clkgen.sv
module test_audio_rate_clkgen;
   localparam int CLK_PERIOD = 10;
   localparam int NREF       = 4;
   localparam int WATCHDOG   = 150000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NREF-1:0] ref_tick = '0;
   logic            bus_wr = 1'b0;
   logic [3:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic            clk_a_out, clk_b_out, en_a, en_b;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;
   bit done     = 0;

   audio_rate_clkgen i_audio_rate_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .clk_a_out (clk_a_out),
      .clk_b_out (clk_b_out),
      .en_a      (en_a),
      .en_b      (en_b)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state, per channel
   int m_sel[2], m_pend[2], m_act[2], m_cnt[2], m_out[2];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_sel[c] = 0; m_pend[c] = 2; m_act[c] = 2; m_cnt[c] = 0; m_out[c] = 0;
         end
      end else begin
         for (int c = 0; c < 2; c++) begin
            if (m_sel[c] >= NREF) begin
               m_cnt[c] = 0; m_out[c] = 0;
            end else if (ref_tick[m_sel[c]]) begin
               int half;
               half = (1 << (2 * (m_act[c] >> 8))) * ((m_act[c] & 255) + 1);
               if (m_cnt[c] == half - 1) begin
                  m_cnt[c] = 0;
                  if (m_out[c] == 1) m_act[c] = m_pend[c];
                  m_out[c] = 1 - m_out[c];
               end else begin
                  m_cnt[c]++;
               end
            end
         end
         if (bus_wr) begin
            case (bus_addr)
               4'd0: begin
                  m_sel[0] = (bus_wdata >> 20) & 15;
                  m_sel[1] = (bus_wdata >> 16) & 15;
               end
               4'd1: m_pend[0] = bus_wdata & 32'h3FF;
               4'd2: m_pend[1] = bus_wdata & 32'h3FF;
               default: ;
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(clk_a_out == m_out[0], "R2 R3 R6 R8 R9 chA out", clk_a_out, m_out[0]);
         check(clk_b_out == m_out[1], "R2 R3 R6 R8 R9 chB out", clk_b_out, m_out[1]);
         check(en_a == (m_sel[0] < NREF), "R6 R7 en_a", en_a, m_sel[0] < NREF);
         check(en_b == (m_sel[1] < NREF), "R6 R7 en_b", en_b, m_sel[1] < NREF);
      end
   end

   // reference tick generators: every cycle, every 2nd, pseudo-random, every 3rd
   initial begin
      logic [7:0] lfsr = 8'hA5;
      int ph = 0;
      forever begin
         @(negedge clk);
         ph++;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         ref_tick[0] <= 1'b1;
         ref_tick[1] <= (ph % 2) == 0;
         ref_tick[2] <= lfsr[0];
         ref_tick[3] <= (ph % 3) == 0;
      end
   end

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr <= 1'b1; bus_addr <= a; bus_wdata <= d;
      @(negedge clk);
      bus_wr <= 1'b0; bus_wdata <= '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(WATCHDOG * CLK_PERIOD);
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int toggles, highs, rises;
      logic prev;
      idle(3);
      @(negedge clk) rst_n <= 1'b1;
      @(negedge clk);
      // R1 reset state
      check(clk_a_out == 0 && clk_b_out == 0, "R1 outs low", clk_a_out | clk_b_out, 0);
      check(en_a == 1 && en_b == 1, "R1 enables", en_a & en_b, 1);
      // R1 default divide-by-6 on ref0: 2 rising edges of A in 12 cycles after warm-up
      idle(4);
      rises = 0; prev = clk_a_out;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (clk_a_out && !prev) rises++;
         prev = clk_a_out;
      end
      check(rises == 2, "R1 default div6", rises, 2);

      // R2 upper bits ignored: div 4 on A
      bus_write(4'd1, 32'hFFFF_FC01);
      // R2 code1 N3 on B -> 32
      bus_write(4'd2, 32'h0000_0103);
      // R5 select A=2, B=1 with garbage elsewhere
      bus_write(4'd0, 32'hFF21_FFFF);
      check(en_a == 1 && en_b == 1, "R5 enables after sel write", en_a & en_b, 1);
      idle(400);

      // R8 mid-period rewrites at varied phases
      for (int k = 0; k < 6; k++) begin
         bus_write(4'd1, 32'(k % 3));
         idle(3 + k);
         bus_write(4'd2, 32'h100 + 32'(k));
         idle(7 + 2 * k);
      end
      idle(300);

      // R4 minimum division on ref0 for A, B keeps ref1
      bus_write(4'd1, 32'h0);
      bus_write(4'd0, 32'h0001_0000);
      idle(60);
      toggles = 0; prev = clk_a_out;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (clk_a_out != prev) toggles++;
         prev = clk_a_out;
      end
      check(toggles == 20, "R4 toggle every tick", toggles, 20);

      // R7 unpopulated select forces low; wait for A high first
      bus_write(4'd1, 32'h1);
      idle(20);
      while (!clk_a_out) @(negedge clk);
      bus_write(4'd0, 32'h0091_0000);
      check(en_a == 0, "R7 en_a low", en_a, 0);
      highs = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (clk_a_out) highs++;
      end
      check(highs == 0, "R7 held low", highs, 0);
      check(en_b == 1, "R6 chB independent", en_b, 1);
      bus_write(4'd0, 32'h0031_0000);
      check(en_a == 1, "R7 recovers", en_a, 1);
      idle(200);

      // R10 writes to unmapped addresses change nothing
      bus_write(4'd3, 32'hFFFF_FFFF);
      bus_write(4'd7, 32'h0000_0000);
      bus_write(4'd15, 32'h00F0_0000);
      check(en_a == 1 && en_b == 1, "R10 select untouched", en_a & en_b, 1);
      idle(200);

      // R2 largest prescaler: code3 N1 -> 256 on B, both channels on ref2
      bus_write(4'd2, 32'h301);
      bus_write(4'd0, 32'h0022_0000);
      idle(3000);

      done = 1;
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule